// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Mode-Fault Demotion

This block is a serial peripheral interface engine that moves one byte at a time and can act as the clock-driving side or the clock-following side of the link. A configuration write chooses the role and the clock format. The format has a polarity bit that sets the idle level of the serial clock and a phase bit that picks the sampling edge. Every pin of the link has its own output-enable, so the pad ring decides what reaches the board. Software starts a byte by writing the transmit port. Completion is reported through a sticky flag and an optional interrupt.

When the block is the clock source and its select line is set to be an input, another device pulling that line low is taken as a competing controller. The block then clears its own role bit and becomes a follower. It stops driving its clock and data outputs and raises the completion flag. The role bit stays cleared until software writes it again. As a follower, the block works only while its select input is low. A rising select discards any partly received byte, so the bit counter stays aligned with the remote clock source.

Top module: `spi_duplex_core`

## Requirements
- R1: The phase bit chooses the sampling edge. Phase 0 samples on the leading SCK edge and changes data on the trailing edge. Phase 1 changes data on the leading edge and samples on the trailing edge. The leading edge is the one that leaves the polarity (idle) level.
- R2: Bytes move most significant bit first. After the 8th sampling edge, `rxData` holds the received byte and `doneFlag` is set on the next clock.
- R3: `doneFlag` stays set until a cycle with `flagClr` high, and a new set wins over a clear. `irq` is high exactly when `doneFlag` and the interrupt-enable bit are both high.
- R4: In clock-source mode, SCK rests at the polarity level. It toggles once every 2 system clocks during a byte, which gives 16 edges, and it returns to rest when the byte ends.
- R5: After reset, all output-enables, `doneFlag`, `irq` and `masterOn` are low. An enabled clock source drives `sckOe` and `mosiOe` high and keeps `misoOe` low.
- R6: In clock-source mode with select direction set to output (`cfgSelDir`=1), `selOe` is high and `selOut` follows `cfgSelLevel`. The level on `selIn` then has no effect on role or transfers.
- R7: In clock-source mode with `cfgSelDir`=0, a low `selIn` (after a two-flop synchroniser) clears `masterOn`, sets `doneFlag` and drops `sckOe` and `mosiOe`.
- R8: After a mode fault, `masterOn` stays low while `selIn` returns high. It goes high again only through a configuration write with `cfgMaster`=1.
- R9: In follower mode, `misoOe` is high only while the synchronised select is low and `cfgMisoDrive`=1.
- R10: In follower mode with select high, SCK and MOSI activity neither sets `doneFlag` nor changes `rxData`.
- R11: In follower mode, a rising select discards a partly received byte. The next byte after select falls is received whole and correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Block enable |
| cfgMaster | input | 1 | 1 = clock source, 0 = follower |
| cfgCpol | input | 1 | SCK idle level |
| cfgCpha | input | 1 | Sampling edge select |
| cfgIrqEn | input | 1 | Interrupt enable |
| cfgSelDir | input | 1 | Select direction in clock-source mode (1 = output) |
| cfgSelLevel | input | 1 | Level driven on select when it is an output |
| cfgMisoDrive | input | 1 | Allow MISO drive in follower mode |
| txWe | input | 1 | Transmit write strobe |
| txData | input | DATA_W | Byte to send |
| flagClr | input | 1 | Write-one clear of the completion flag |
| rxData | output | DATA_W | Last completed received byte |
| doneFlag | output | 1 | Completion / mode-fault flag |
| irq | output | 1 | Interrupt request |
| masterOn | output | 1 | Current role bit |
| sckIn | input | 1 | SCK pad input |
| sckOut | output | 1 | SCK pad output |
| sckOe | output | 1 | SCK output enable |
| mosiIn | input | 1 | MOSI pad input |
| mosiOut | output | 1 | MOSI pad output |
| mosiOe | output | 1 | MOSI output enable |
| misoIn | input | 1 | MISO pad input |
| misoOut | output | 1 | MISO pad output |
| misoOe | output | 1 | MISO output enable |
| selIn | input | 1 | Select pad input |
| selOut | output | 1 | Select pad output |
| selOe | output | 1 | Select output enable |

## Verification
The bench uses the default build: an 8-bit word, a half-period of 2 system clocks and two synchroniser stages. The short half-period keeps each clock-source byte to 32 cycles, so all four clock formats fit in a short run, and the bench can measure the exact 16 ns spacing between edges. The two-stage synchroniser makes the reaction to select and to the remote clock a known 3-cycle lag. The bench therefore drives its follower-mode clock with an 8-cycle half-period, and it can time the fault and the resync checks within a few cycles.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
  // Per-cycle commands from the control side to the shift datapath.
  typedef struct packed {
    logic load;    // capture a new transmit byte
    logic sample;  // take one received bit
    logic shift;   // advance the transmit register by one bit
    logic clear;   // drop any partly received bits
    logic done;    // last bit of the byte: publish the received byte
  } spiStrobe_t;
endpackage

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
  import spi_duplex_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgEnable,
  input  logic       cfgMaster,
  input  logic       cfgCpol,
  input  logic       cfgCpha,
  input  logic       cfgIrqEn,
  input  logic       cfgSelDir,
  input  logic       cfgSelLevel,
  input  logic       cfgMisoDrive,
  input  logic       txWe,
  input  logic       flagClr,
  input  logic       sckIn,
  input  logic       selIn,
  output spiStrobe_t strb,
  output logic       masterOn,
  output logic       doneFlag,
  output logic       irq,
  output logic       sckOut,
  output logic       sckOe,
  output logic       mosiOe,
  output logic       misoOe,
  output logic       selOut,
  output logic       selOe
);
  localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
  localparam logic [DIV_W-1:0]  DIV_TOP   = DIV_W'(HALF_DIV - 1);

  // configuration state
  logic enR, masterR, cpolR, cphaR, irqEnR, selDirR, selLevelR, misoDriveR;
  // synchronisers
  logic [SYNC_STAGES-1:0] selSync, sckSync;
  logic selPrev, sckPrev, selNow, sckNow;
  // engine state
  logic [CNT_W-1:0]  bitCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [DIV_W-1:0]  divCnt;
  logic busyR, sckR, flagR;

  logic slaveActive, modeFault, selRise, divEdge, edgeNow, newLevel, leading;
  logic sampleSide, startXfer;

  assign selNow = selSync[SYNC_STAGES-1];
  assign sckNow = sckSync[SYNC_STAGES-1];

  always_comb begin
    slaveActive = enR && !masterR && !selNow;
    modeFault   = enR && masterR && !selDirR && !selNow;
    selRise     = enR && !masterR && selNow && !selPrev;
    divEdge     = busyR && (divCnt == DIV_TOP);
    edgeNow     = masterR ? divEdge : (slaveActive && (sckNow != sckPrev));
    newLevel    = masterR ? ~sckR : sckNow;
    leading     = (newLevel != cpolR);
    sampleSide  = leading ^ cphaR;
    startXfer   = txWe && enR && masterR && !busyR && !modeFault;

    strb.load   = txWe && (startXfer || !masterR);
    strb.sample = edgeNow && sampleSide && !modeFault;
    strb.shift  = edgeNow && !sampleSide && (bitCnt != '0) && !modeFault;
    strb.done   = strb.sample && (bitCnt == LAST_BIT);
    strb.clear  = modeFault || selRise || !enR || cfgWe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enR        <= 1'b0;
      masterR    <= 1'b0;
      cpolR      <= 1'b0;
      cphaR      <= 1'b0;
      irqEnR     <= 1'b0;
      selDirR    <= 1'b0;
      selLevelR  <= 1'b1;
      misoDriveR <= 1'b0;
      selSync    <= '1;
      sckSync    <= '0;
      selPrev    <= 1'b1;
      sckPrev    <= 1'b0;
    end else begin
      selSync <= {selSync[SYNC_STAGES-2:0], selIn};
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      selPrev <= selNow;
      sckPrev <= sckNow;
      if (cfgWe) begin
        enR        <= cfgEnable;
        masterR    <= cfgMaster;
        cpolR      <= cfgCpol;
        cphaR      <= cfgCpha;
        irqEnR     <= cfgIrqEn;
        selDirR    <= cfgSelDir;
        selLevelR  <= cfgSelLevel;
        misoDriveR <= cfgMisoDrive;
      end else if (modeFault) begin
        masterR <= 1'b0;
      end
    end
  end

  // bit counter shared by both roles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.clear || startXfer) begin
      bitCnt <= '0;
    end else if (strb.sample) begin
      bitCnt <= strb.done ? '0 : bitCnt + 1'b1;
    end
  end

  // clock generator for the clock-source role
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckR    <= 1'b0;
    end else begin
      if (strb.clear) begin
        busyR   <= 1'b0;
        divCnt  <= '0;
        edgeCnt <= '0;
      end else if (startXfer) begin
        busyR   <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
      end else if (busyR) begin
        divCnt <= divEdge ? '0 : divCnt + 1'b1;
        if (divEdge) begin
          edgeCnt <= edgeCnt + 1'b1;
          if (edgeCnt == LAST_EDGE) busyR <= 1'b0;
        end
      end
      if (masterR && divEdge && !modeFault && !strb.clear) sckR <= ~sckR;
      else if (!busyR) sckR <= cpolR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        flagR <= 1'b0;
    else if (strb.done || modeFault)  flagR <= 1'b1;
    else if (flagClr)                 flagR <= 1'b0;
  end

  assign masterOn = masterR;
  assign doneFlag = flagR;
  assign irq      = flagR && irqEnR;
  assign sckOut   = sckR;
  assign sckOe    = enR && masterR;
  assign mosiOe   = enR && masterR;
  assign misoOe   = enR && !masterR && !selNow && misoDriveR;
  assign selOe    = enR && masterR && selDirR;
  assign selOut   = selLevelR;
endmodule

// File: rtl/spi_duplex_datapath.sv
module spi_duplex_datapath
  import spi_duplex_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strb,
  input  logic              isMaster,
  input  logic [DATA_W-1:0] txData,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData
);
  logic [SYNC_STAGES-1:0] mosiSync;
  logic [DATA_W-1:0] txShift, rxShift, rxNext;
  logic inBit;

  // follower data passes the same number of stages as the follower clock
  assign inBit  = isMaster ? misoIn : mosiSync[SYNC_STAGES-1];
  assign rxNext = {rxShift[DATA_W-2:0], inBit};
  assign txBit  = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosiSync <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      rxData   <= '0;
    end else begin
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      if (strb.load)       txShift <= txData;
      else if (strb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.clear)       rxShift <= '0;
      else if (strb.sample) rxShift <= rxNext;
      if (strb.done) rxData <= rxNext;
    end
  end
endmodule

// File: rtl/spi_duplex_core.sv
module spi_duplex_core
  import spi_duplex_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgEnable,
  input  logic              cfgMaster,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgIrqEn,
  input  logic              cfgSelDir,
  input  logic              cfgSelLevel,
  input  logic              cfgMisoDrive,
  input  logic              txWe,
  input  logic [DATA_W-1:0] txData,
  input  logic              flagClr,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              irq,
  output logic              masterOn,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              selIn,
  output logic              selOut,
  output logic              selOe
);
  spiStrobe_t strb;
  logic txBit;

  spi_duplex_ctrl #(
    .DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgMaster(cfgMaster), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgIrqEn(cfgIrqEn), .cfgSelDir(cfgSelDir), .cfgSelLevel(cfgSelLevel),
    .cfgMisoDrive(cfgMisoDrive), .txWe(txWe), .flagClr(flagClr),
    .sckIn(sckIn), .selIn(selIn), .strb(strb), .masterOn(masterOn),
    .doneFlag(doneFlag), .irq(irq), .sckOut(sckOut), .sckOe(sckOe),
    .mosiOe(mosiOe), .misoOe(misoOe), .selOut(selOut), .selOe(selOe)
  );

  spi_duplex_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .isMaster(masterOn),
    .txData(txData), .mosiIn(mosiIn), .misoIn(misoIn),
    .txBit(txBit), .rxData(rxData)
  );

  assign mosiOut = txBit;
  assign misoOut = txBit;
endmodule

// File: rtl/spi_duplex_checker.sv
module spi_duplex_checker (
  input logic clk,
  input logic rstN,
  input logic cfgWe,
  input logic cfgMaster,
  input logic flagClr,
  input logic doneFlag,
  input logic irq,
  input logic masterOn,
  input logic sckOut,
  input logic sckOe,
  input logic misoOe,
  input logic selOe
);
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !flagClr |=> doneFlag);

  assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  assert_sck_half_period_R4: assert property (@(posedge clk) disable iff (!rstN)
    sckOe && $past(sckOe) && !$stable(sckOut) |=> $stable(sckOut));

  assert_sel_out_master_R6: assert property (@(posedge clk) disable iff (!rstN)
    selOe |-> masterOn && sckOe);

  assert_fault_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(masterOn) && !$past(cfgWe) |-> doneFlag);

  assert_role_by_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterOn) |-> $past(cfgWe && cfgMaster));

  assert_miso_follower_R9: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !masterOn && !sckOe);
endmodule

bind spi_duplex_core spi_duplex_checker chk (.*);

// File: tb/spi_duplex_core_test.sv
`timescale 1ns/1ps
module spi_duplex_core_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgEnable = 0, cfgMaster = 0, cfgCpol = 0, cfgCpha = 0;
  logic cfgIrqEn = 0, cfgSelDir = 0, cfgSelLevel = 1, cfgMisoDrive = 0;
  logic txWe = 0, flagClr = 0;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic doneFlag, irq, masterOn;
  logic sckIn = 0, mosiIn = 0, misoIn = 0, selIn = 1;
  logic sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe, selOut, selOe;

  int testsRun = 0;
  int testsFailed = 0;
  localparam int HALF = 8;

  always #4 clk = ~clk;

  spi_duplex_core uut (.*);

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic setCfg(input logic en, mst, pol, pha, ie, sdir, slvl, mdrv);
    @(negedge clk);
    cfgEnable = en; cfgMaster = mst; cfgCpol = pol; cfgCpha = pha;
    cfgIrqEn = ie; cfgSelDir = sdir; cfgSelLevel = slvl; cfgMisoDrive = mdrv;
    cfgWe = 1;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0;
  endtask

  task automatic writeTx(input logic [7:0] b);
    @(negedge clk); txData = b; txWe = 1;
    @(negedge clk); txWe = 0;
  endtask

  // clock-source transfer against a bench follower model (R1, R2, R3, R4, R5)
  task automatic masterXfer(input logic pol, pha, input logic [7:0] txB,
                            input logic [7:0] slvB, input logic ie);
    logic [7:0] got = '0;
    int n = 0;
    longint tFirst = 0, tSecond = 0;
    setCfg(1, 1, pol, pha, ie, 1, 1, 0);
    clearFlag();
    check(sckOut == pol, "R4 idle level", sckOut, pol);
    misoIn = slvB[7];
    writeTx(txB);
    for (int e = 0; e < 16; e++) begin
      @(sckOut); #1;
      if (e == 0) tFirst = $time;
      if (e == 1) tSecond = $time;
      if ((sckOut != pol) ^ pha) begin
        got = {got[6:0], mosiOut};
        n++;
      end else if (n < 8) begin
        misoIn = slvB[7 - n];
      end
    end
    repeat (3) @(negedge clk);
    check(got == txB, "R1 bits seen by follower", got, txB);
    check(rxData == slvB, "R2 received byte", rxData, slvB);
    check(doneFlag == 1'b1, "R2 flag after byte", doneFlag, 1);
    check(irq == ie, "R3 irq gating", irq, ie);
    check(tSecond - tFirst == 16, "R4 edge spacing", tSecond - tFirst, 16);
    check(sckOut == pol, "R4 rest after byte", sckOut, pol);
    check(sckOe && mosiOe && !misoOe, "R5 drivers", {sckOe, mosiOe, misoOe}, 3'b110);
    clearFlag();
    check(doneFlag == 1'b0 && irq == 1'b0, "R3 write-one clear", {doneFlag, irq}, 0);
  endtask

  // drive n follower-mode bits as the remote clock source
  task automatic slvShift(input logic pol, pha, input logic [7:0] m,
                          input int n, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      if (!pha) begin
        mosiIn = m[7 - i];
        repeat (HALF) @(negedge clk);
        got = {got[6:0], misoOut};
        sckIn = ~pol;
        repeat (HALF) @(negedge clk);
        sckIn = pol;
      end else begin
        sckIn = ~pol;
        mosiIn = m[7 - i];
        repeat (HALF) @(negedge clk);
        got = {got[6:0], misoOut};
        sckIn = pol;
        repeat (HALF) @(negedge clk);
      end
    end
  endtask

  task automatic slaveXfer(input logic pol, pha, input logic [7:0] m,
                           input logic [7:0] s, input logic mdrv);
    logic [7:0] got;
    sckIn = pol; selIn = 1;
    setCfg(1, 0, pol, pha, 0, 0, 1, mdrv);
    clearFlag();
    writeTx(s);
    @(negedge clk); selIn = 0;
    repeat (4) @(negedge clk);
    check(misoOe == mdrv, "R9 miso drive while selected", misoOe, mdrv);
    slvShift(pol, pha, m, 8, got);
    repeat (4) @(negedge clk);
    check(rxData == m, "R1 follower received", rxData, m);
    if (mdrv) check(got == s, "R2 follower sent", got, s);
    check(doneFlag == 1'b1, "R2 follower flag", doneFlag, 1);
    selIn = 1;
    repeat (4) @(negedge clk);
    check(misoOe == 1'b0, "R9 miso released", misoOe, 0);
    clearFlag();
  endtask

  task automatic testReset();
    check({sckOe, mosiOe, misoOe, selOe} == 4'b0, "R5 reset enables",
          {sckOe, mosiOe, misoOe, selOe}, 0);
    check({doneFlag, irq, masterOn} == 3'b0, "R5 reset status",
          {doneFlag, irq, masterOn}, 0);
  endtask

  task automatic testSelOutput();
    selIn = 0;
    setCfg(1, 1, 0, 0, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    check(selOe && selOut == 1'b0, "R6 select drives level", {selOe, selOut}, 2'b10);
    check(masterOn && !doneFlag, "R6 low select ignored", {masterOn, doneFlag}, 2'b10);
    masterXfer(1, 0, 8'h6B, 8'hB6, 0);
    check(masterOn == 1'b1, "R6 role kept with select low", masterOn, 1);
    check(selOut == 1'b1, "R6 select follows level", selOut, 1);
    selIn = 1;
  endtask

  task automatic testModeFault();
    selIn = 1;
    setCfg(1, 1, 0, 0, 1, 0, 1, 0);
    clearFlag();
    writeTx(8'hA5);
    repeat (3) @(negedge clk);
    selIn = 0;
    repeat (4) @(negedge clk);
    check(masterOn == 1'b0, "R7 role cleared", masterOn, 0);
    check(doneFlag && irq, "R7 flag and irq", {doneFlag, irq}, 2'b11);
    check(!sckOe && !mosiOe, "R7 drivers off", {sckOe, mosiOe}, 0);
    selIn = 1;
    repeat (6) @(negedge clk);
    check(masterOn == 1'b0, "R8 stays follower", masterOn, 0);
    setCfg(1, 1, 0, 0, 1, 0, 1, 0);
    @(negedge clk);
    check(masterOn == 1'b1, "R8 restored by write", masterOn, 1);
    clearFlag();
  endtask

  task automatic testResync();
    logic [7:0] got, prev;
    sckIn = 0; selIn = 1;
    setCfg(1, 0, 0, 0, 0, 0, 1, 1);
    clearFlag();
    prev = rxData;
    @(negedge clk); selIn = 0;
    repeat (4) @(negedge clk);
    slvShift(0, 0, 8'hFF, 4, got);
    selIn = 1;
    repeat (6) @(negedge clk);
    check(doneFlag == 1'b0, "R11 partial dropped flag", doneFlag, 0);
    check(rxData == prev, "R11 partial not published", rxData, prev);
    selIn = 0;
    repeat (4) @(negedge clk);
    slvShift(0, 0, 8'h3C, 8, got);
    repeat (4) @(negedge clk);
    check(rxData == 8'h3C, "R11 next byte aligned", rxData, 8'h3C);
    check(doneFlag == 1'b1, "R11 flag after full byte", doneFlag, 1);
    selIn = 1;
    repeat (4) @(negedge clk);
    clearFlag();
  endtask

  task automatic testDeselected();
    logic [7:0] got, prev;
    sckIn = 0; selIn = 1;
    setCfg(1, 0, 0, 0, 0, 0, 1, 1);
    clearFlag();
    prev = rxData;
    slvShift(0, 0, 8'hAA, 8, got);
    repeat (4) @(negedge clk);
    check(doneFlag == 1'b0, "R10 no flag when deselected", doneFlag, 0);
    check(rxData == prev, "R10 rx unchanged", rxData, prev);
    check(misoOe == 1'b0, "R9 no drive when deselected", misoOe, 0);
    selIn = 0;
    repeat (4) @(negedge clk);
    slvShift(0, 0, 8'h55, 8, got);
    repeat (4) @(negedge clk);
    check(rxData == 8'h55, "R10 byte after select", rxData, 8'h55);
    selIn = 1;
    repeat (4) @(negedge clk);
    clearFlag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    masterXfer(0, 0, 8'hA5, 8'h3C, 1);
    masterXfer(0, 1, 8'h81, 8'h7E, 1);
    masterXfer(1, 0, 8'h5A, 8'hC3, 0);
    masterXfer(1, 1, 8'h0F, 8'hF0, 1);
    testSelOutput();
    testModeFault();
    slaveXfer(0, 0, 8'h96, 8'h69, 1);
    slaveXfer(1, 1, 8'h12, 8'hED, 1);
    slaveXfer(0, 1, 8'hC8, 8'h37, 0);
    slaveXfer(1, 0, 8'h4D, 8'hB2, 1);
    testResync();
    testDeselected();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got %0h expected %0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule